// File: doc/BRIEF.md
# Stub Level-2 Cache Controller Register Block

This block stands in for the register interface of a level-2 cache controller when no cache array is present. It answers single-cycle APB-style reads and writes inside a 4 KB window and keeps the control, auxiliary control, tag latency, data latency and address filter start/end registers. Software that probes the controller finds a fixed identification word and a cache type word derived from the auxiliary control settings. Any cache maintenance operation it starts reports completion at once.

The bus transfer has a setup phase (select high, enable low) followed by one access phase (select and enable high). Read data is captured at the end of the setup phase and held throughout the access phase. Writes take effect at the end of the access phase. An access to an offset that has no meaning raises an error strobe during its access phase.

Top module: `l2stub_regs`

## Requirements
- R1: Only address bits 11:0 are decoded; the same offset with any value in bits 31:12 reaches the same register.
- R2: Offset 0x000 reads 0x410000C8. A write to it changes nothing and raises the error strobe.
- R3: Every offset from 0x730 to 0x7FF inclusive, aligned or not, reads as zero, drops writes and raises no error.
- R4: Offset 0x004 returns the cache type word. The word resets to parameter CT_RESET (default 0x1C100100). On each read, a nibble N = {aux[19:17], aux[16]} is shifted left by 18 and by 6, and both copies are ORed into the stored word. The result is returned and stored, so set bits never clear. A write to 0x004 changes nothing and raises the error strobe.
- R5: The control register at 0x100 resets to zero, keeps only write data bit 0, and reads back zero in bits 31:1.
- R6: The auxiliary control register at 0x104 resets to 0x02020000 and stores all 32 written bits.
- R7: The tag latency register at 0x108 and the data latency register at 0x10C reset to zero and store all 32 written bits.
- R8: The filter start register at 0xC00 and the filter end register at 0xC04 reset to zero and store all 32 written bits.
- R9: Offsets 0xF40, 0xF60 and 0xF80 read as zero, drop writes and raise no error.
- R10: Any other offset, including unaligned offsets outside the range in R3, reads as zero and drops writes. It raises the error strobe only in the access phase, for exactly that cycle.
- R11: Ready is always high. Read data changes only at the clock edge that ends a read setup phase, and a write is visible to a read that starts after its access phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busSel | input | 1 | Transfer select |
| busEnable | input | 1 | Access phase marker |
| busWrite | input | 1 | 1 for write, 0 for read |
| busAddr | input | 32 | Byte address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |
| busReady | output | 1 | Always-high ready |
| badAccess | output | 1 | Error strobe for a bad offset or a write to a read-only word |

## Verification
The assertions assume that every transfer follows the protocol: a setup phase of exactly one cycle, then one access phase, with address, direction and write data held constant across both phases. They also assume enable is never high while select is low. The bench drives every transfer through one task that produces exactly this two-cycle pattern and then returns to idle. It never issues back-to-back or malformed phases, so the captured read data and the error strobe always match a well-formed access.

// File: rtl/l2stub_pkg.sv
package l2stub_pkg;
  localparam int OFFS_W    = 12;
  localparam int NUM_PLAIN = 5;  // aux, tag lat, data lat, filter start, filter end
  localparam int PIDX_W    = $clog2(NUM_PLAIN);

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_ID,
    SEL_CTYPE,
    SEL_CTRL,
    SEL_PLAIN
  } rdSel_e;

  typedef struct packed {
    logic              rdCapture;
    logic              wrCommit;
    rdSel_e            rdSel;
    logic              ctrlHit;
    logic              plainHit;
    logic [PIDX_W-1:0] plainIdx;
  } strobes_t;
endpackage

// File: rtl/l2stub_ctrl.sv
module l2stub_ctrl
  import l2stub_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  output strobes_t          strb,
  output logic              badAccess
);
  localparam logic [OFFS_W-1:0] PLAIN_OFFS [NUM_PLAIN] =
    '{12'h104, 12'h108, 12'h10C, 12'hC00, 12'hC04};
  localparam logic [OFFS_W-1:0] MAINT_LO = 12'h730;
  localparam logic [OFFS_W-1:0] MAINT_HI = 12'h800;

  logic [OFFS_W-1:0] offs;
  logic hitId, hitCt, hitCtrl, hitMaint, hitNop, hitPlain, known, roWrite;
  logic [PIDX_W-1:0] plainIdx;
  logic setupPh, accessPh;

  assign offs = busAddr[OFFS_W-1:0];

  always_comb begin
    hitPlain = 1'b0;
    plainIdx = '0;
    for (int i = 0; i < NUM_PLAIN; i++) begin
      if (offs == PLAIN_OFFS[i]) begin
        hitPlain = 1'b1;
        plainIdx = PIDX_W'(i);
      end
    end
  end

  assign hitId    = (offs == 12'h000);
  assign hitCt    = (offs == 12'h004);
  assign hitCtrl  = (offs == 12'h100);
  assign hitMaint = (offs >= MAINT_LO) && (offs < MAINT_HI);
  assign hitNop   = (offs == 12'hF40) || (offs == 12'hF60) || (offs == 12'hF80);
  assign known    = hitId | hitCt | hitCtrl | hitMaint | hitNop | hitPlain;
  assign roWrite  = busWrite && (hitId || hitCt);

  assign setupPh  = busSel && !busEnable;
  assign accessPh = busSel && busEnable;

  always_comb begin
    strb.rdCapture = setupPh && !busWrite;
    strb.wrCommit  = accessPh && busWrite;
    strb.ctrlHit   = hitCtrl;
    strb.plainHit  = hitPlain;
    strb.plainIdx  = plainIdx;
    if (hitId)         strb.rdSel = SEL_ID;
    else if (hitCt)    strb.rdSel = SEL_CTYPE;
    else if (hitCtrl)  strb.rdSel = SEL_CTRL;
    else if (hitPlain) strb.rdSel = SEL_PLAIN;
    else               strb.rdSel = SEL_ZERO;
  end

  assign badAccess = accessPh && (!known || roWrite);
endmodule

// File: rtl/l2stub_dp.sv
module l2stub_dp
  import l2stub_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter logic [31:0] ID_VALUE  = 32'h410000C8,
  parameter logic [31:0] CT_RESET  = 32'h1C100100,
  parameter logic [31:0] AUX_RESET = 32'h02020000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int NIB_W   = 4;
  localparam int HI_POS  = 18;
  localparam int LO_POS  = 6;

  logic [DATA_W-1:0] plainReg [NUM_PLAIN];
  logic [DATA_W-1:0] ctReg, ctNext, readVal, rdataQ;
  logic              ctrlBit;
  logic [NIB_W-1:0]  ctNib;

  for (genvar i = 0; i < NUM_PLAIN; i++) begin : g_plain
    localparam logic [DATA_W-1:0] RST = (i == 0) ? DATA_W'(AUX_RESET) : '0;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        plainReg[i] <= RST;
      else if (strb.wrCommit && strb.plainHit && strb.plainIdx == PIDX_W'(i))
        plainReg[i] <= wdata;
    end
  end

  assign ctNib  = {plainReg[0][19:17], plainReg[0][16]};
  assign ctNext = ctReg | (DATA_W'(ctNib) << HI_POS) | (DATA_W'(ctNib) << LO_POS);

  always_comb begin
    unique case (strb.rdSel)
      SEL_ID:    readVal = DATA_W'(ID_VALUE);
      SEL_CTYPE: readVal = ctNext;
      SEL_CTRL:  readVal = {{(DATA_W-1){1'b0}}, ctrlBit};
      SEL_PLAIN: readVal = plainReg[strb.plainIdx];
      default:   readVal = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctReg   <= DATA_W'(CT_RESET);
      ctrlBit <= 1'b0;
      rdataQ  <= '0;
    end else begin
      if (strb.rdCapture) begin
        rdataQ <= readVal;
        if (strb.rdSel == SEL_CTYPE) ctReg <= ctNext;
      end
      if (strb.wrCommit && strb.ctrlHit) ctrlBit <= wdata[0];
    end
  end

  assign rdata = rdataQ;
endmodule

// File: rtl/l2stub_regs.sv
module l2stub_regs
  import l2stub_pkg::*;
#(
  parameter int          ADDR_W    = 32,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] ID_VALUE  = 32'h410000C8,
  parameter logic [31:0] CT_RESET  = 32'h1C100100,
  parameter logic [31:0] AUX_RESET = 32'h02020000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busEnable,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busReady,
  output logic              badAccess
);
  strobes_t strb;

  l2stub_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busSel(busSel), .busEnable(busEnable), .busWrite(busWrite),
    .busAddr(busAddr), .strb(strb), .badAccess(badAccess)
  );

  l2stub_dp #(
    .DATA_W(DATA_W), .ID_VALUE(ID_VALUE),
    .CT_RESET(CT_RESET), .AUX_RESET(AUX_RESET)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .rdata(busRdata)
  );

  assign busReady = 1'b1;
endmodule

// File: rtl/l2stub_chk.sv
module l2stub_chk #(
  parameter int          ADDR_W   = 32,
  parameter int          DATA_W   = 32,
  parameter logic [31:0] ID_VALUE = 32'h410000C8,
  parameter logic [31:0] CT_RESET = 32'h1C100100
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busEnable,
  input logic              busWrite,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busRdata,
  input logic              badAccess
);
  logic rdSetup, accessPh;
  logic [11:0] offs;
  assign rdSetup  = busSel && !busEnable && !busWrite;
  assign accessPh = busSel && busEnable;
  assign offs     = busAddr[11:0];

  // R2
  id_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSetup && offs == 12'h000 |=> busRdata == DATA_W'(ID_VALUE));

  // R3
  maint_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSetup && offs >= 12'h730 && offs < 12'h800 |=> busRdata == '0);

  // R3
  maint_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessPh && offs >= 12'h730 && offs < 12'h800 |-> !badAccess);

  // R4
  ctype_keeps_reset_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSetup && offs == 12'h004 |=> (busRdata & DATA_W'(CT_RESET)) == DATA_W'(CT_RESET));

  // R5
  ctrl_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdSetup && offs == 12'h100 |=> busRdata[DATA_W-1:1] == '0);

  // R9
  nop_no_err_chk: assert property (@(posedge clk) disable iff (!rstN)
    accessPh && (offs == 12'hF40 || offs == 12'hF60 || offs == 12'hF80) |-> !badAccess);

  // R10
  err_in_access_chk: assert property (@(posedge clk) disable iff (!rstN)
    badAccess |-> accessPh);

  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdSetup |=> $stable(busRdata));
endmodule

bind l2stub_regs l2stub_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ID_VALUE(ID_VALUE), .CT_RESET(CT_RESET)
) u_chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
  .busWrite(busWrite), .busAddr(busAddr), .busRdata(busRdata),
  .badAccess(badAccess)
);

// File: tb/l2stub_regs_bench.sv
`timescale 1ns/1ps
module l2stub_regs_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busEnable = 1'b0, busWrite = 1'b0;
  logic [31:0] busAddr = '0, busWdata = '0;
  logic [31:0] busRdata;
  logic        busReady, badAccess;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // model registers
  logic [31:0] mCt, mAux, mTag, mDat, mFs, mFe;
  logic        mCtrl;

  always #2 clk = ~clk;

  l2stub_regs u_l2stub_regs (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busEnable(busEnable),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .busReady(busReady), .badAccess(badAccess)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit wr, input logic [31:0] addr, input logic [31:0] wd,
                      output logic [31:0] rd, output logic err, output logic rdy);
    @(negedge clk);
    busSel = 1; busEnable = 0; busWrite = wr; busAddr = addr; busWdata = wd;
    @(negedge clk);
    busEnable = 1;
    #1;
    rd = busRdata; err = badAccess; rdy = busReady;
    @(negedge clk);
    busSel = 0; busEnable = 0; busWrite = 0;
    #1;
    if (badAccess) begin
      checks++; errors++;
      $display("FAIL R10: error strobe held after access actual 1 expected 0");
    end
  endtask

  function automatic bit isKnown(input logic [11:0] o);
    return o == 12'h000 || o == 12'h004 || o == 12'h100 || o == 12'h104 ||
           o == 12'h108 || o == 12'h10C || o == 12'hC00 || o == 12'hC04 ||
           o == 12'hF40 || o == 12'hF60 || o == 12'hF80 ||
           (o >= 12'h730 && o < 12'h800);
  endfunction

  function automatic logic [31:0] ctStep();
    logic [3:0] n;
    n = {mAux[19:17], mAux[16]};
    mCt = mCt | (32'(n) << 18) | (32'(n) << 6);
    return mCt;
  endfunction

  function automatic logic [31:0] expRead(input logic [11:0] o);
    case (o)
      12'h000: return 32'h410000C8;
      12'h004: return ctStep();
      12'h100: return {31'b0, mCtrl};
      12'h104: return mAux;
      12'h108: return mTag;
      12'h10C: return mDat;
      12'hC00: return mFs;
      12'hC04: return mFe;
      default: return 32'h0;
    endcase
  endfunction

  function automatic void modelWrite(input logic [11:0] o, input logic [31:0] d);
    case (o)
      12'h100: mCtrl = d[0];
      12'h104: mAux = d;
      12'h108: mTag = d;
      12'h10C: mDat = d;
      12'hC00: mFs = d;
      12'hC04: mFe = d;
      default: ;
    endcase
  endfunction

  function automatic string tagOf(input logic [11:0] o);
    if (o == 12'h000) return "R2";
    if (o == 12'h004) return "R4";
    if (o == 12'h100) return "R5";
    if (o == 12'h104) return "R6";
    if (o == 12'h108 || o == 12'h10C) return "R7";
    if (o == 12'hC00 || o == 12'hC04) return "R8";
    if (o >= 12'h730 && o < 12'h800) return "R3";
    if (o == 12'hF40 || o == 12'hF60 || o == 12'hF80) return "R9";
    return "R10";
  endfunction

  task automatic doRead(input logic [31:0] addr, input string req);
    logic [31:0] rd, exp; logic err, rdy;
    logic [11:0] o;
    o = addr[11:0];
    exp = expRead(o);
    xfer(0, addr, 32'hDEADBEEF, rd, err, rdy);
    check(rd == exp, req, rd, exp);
    check(err == !isKnown(o), "R10", 32'(err), 32'(!isKnown(o)));
    check(rdy == 1'b1, "R11", 32'(rdy), 32'h1);
  endtask

  task automatic doWrite(input logic [31:0] addr, input logic [31:0] d);
    logic [31:0] rd; logic err, rdy, expErr;
    logic [11:0] o;
    o = addr[11:0];
    expErr = !isKnown(o) || o == 12'h000 || o == 12'h004;
    modelWrite(o, d);
    xfer(1, addr, d, rd, err, rdy);
    check(err == expErr, (o == 12'h000) ? "R2" : (o == 12'h004) ? "R4" : "R10",
          32'(err), 32'(expErr));
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    mCt = 32'h1C100100; mAux = 32'h02020000; mTag = '0; mDat = '0;
    mFs = '0; mFe = '0; mCtrl = 0;
    repeat (3) @(negedge clk);
    rstN = 1;

    // reset state
    check(busRdata == 32'h0, "R11", busRdata, 32'h0);
    check(badAccess == 1'b0, "R10", 32'(badAccess), 32'h0);
    doRead(32'h0000_0104, "R6");
    doRead(32'h0000_0108, "R7");
    doRead(32'h0000_010C, "R7");
    doRead(32'h0000_0C00, "R8");
    doRead(32'h0000_0C04, "R8");
    doRead(32'h0000_0100, "R5");
    // R4: first read from reset equals 0x1C180180
    doRead(32'h0000_0004, "R4");
    check(mCt == 32'h1C180180, "R4", mCt, 32'h1C180180);

    // R5: only bit 0 kept
    doWrite(32'h0000_0100, 32'hFFFF_FFFE);
    doRead(32'h0000_0100, "R5");
    doWrite(32'h0000_0100, 32'hFFFF_FFFF);
    doRead(32'h0000_0100, "R5");

    // R4: sticky accumulation across aux changes
    doWrite(32'h0000_0104, 32'h0001_0000);
    doRead(32'h0000_0004, "R4");
    doWrite(32'h0000_0104, 32'h000E_0000);
    doRead(32'h0000_0004, "R4");
    doWrite(32'h0000_0104, 32'h0);
    doRead(32'h0000_0004, "R4");
    doWrite(32'h0000_0004, 32'h0);   // R4 write ignored
    doRead(32'h0000_0004, "R4");
    doWrite(32'h0000_0000, 32'hFFFF_FFFF); // R2 write ignored
    doRead(32'h0000_0000, "R2");

    // unaligned offsets: inside maintenance range vs elsewhere
    doWrite(32'h0000_0731, 32'h1234_5678);
    doRead(32'h0000_07FF, "R3");
    doWrite(32'h0000_0101, 32'hFFFF_FFFF);
    doRead(32'h0000_0101, "R10");
    doRead(32'h0000_0100, "R5");

    // write sweep over every word offset, high address bits varied (R1)
    for (int w = 0; w < 1024; w++) begin
      logic [31:0] a;
      a = {20'(w * 32'h9E37), 12'(w * 4)};
      doWrite(a, 32'h5A5A_0000 ^ (32'(w) * 32'h0001_0203));
    end
    // read sweep over every word offset through another alias (R1)
    for (int w = 0; w < 1024; w++) begin
      logic [31:0] a;
      a = {20'(~(w * 32'h7F4A)), 12'(w * 4)};
      doRead(a, (w == 0) ? "R1" : tagOf(12'(w * 4)));
    end

    // write-then-read ordering (R11)
    doWrite(32'hFFFF_FC00, 32'hCAFE_F00D);
    doRead(32'h0000_0C00, "R11");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule